// File: doc/BRIEF.md
# Paged Indirect Debug Window Bridge

This block sits behind a 16-bit management register port (register address, write data, write strobe, read strobe, read data) and gives that port indirect access to a bank of wide internal debug registers. A page-select register chooses what the three registers at 0x10, 0x11 and 0x12 mean. On the standard page they are three ordinary 16-bit scratch registers. On one magic page, 0x52B5, they become a command register and a two-half data window.

Software reaches a debug register in two ways. To write one, it loads the low and high data halves, then issues a command word with the start bit set and the read flag clear. To read one, it issues a command with both the start and read bits set, waits for the access to finish, then reads the two halves back. The command word carries a channel, node and data address. The debug bank is indexed by the low `IDX_W` bits of that concatenated address, and each entry keeps `STORE_W` significant bits.

Top module: `dbg_window_bridge`

## Requirements
- R1: After reset, the page register, the last command, the data window and the standard registers all read 0x0000, and every debug entry holds zero.
- R2: Register 0x1F is the page register: a write stores the full 16-bit value, and a read returns it on any page.
- R3: On page 0x52B5, a write to 0x11 sets the low window half and a write to 0x12 sets the high window half; reads of 0x11 and 0x12 return those halves.
- R4: On page 0x52B5, writing 0x10 with bit 15 set and bit 13 clear commits the word {high half, low half} to the addressed entry. Only the low STORE_W bits (default 24) are kept, so a later read returns zero in the bits above them.
- R5: On page 0x52B5, writing 0x10 with bits 15 and 13 both set loads the addressed entry into the window; 0x11 then returns bits [15:0] and 0x12 returns the bits above 15.
- R6: The command word places the channel at bits [12:11], the node at [10:7] and the data address at [6:1]. The entry index is the low IDX_W bits (default 8) of {channel, node, data}, so addresses that agree in those bits reach the same entry and addresses that differ there reach different entries.
- R7: Command bits 14 and 0 have no effect on which entry is accessed or on the data moved.
- R8: A started access keeps bit 15 of a 0x10 read at 1 for the two cycles after the command write, then 0. Bits [14:0] of a 0x10 read return the last accepted command word.
- R9: A command write while bit 15 still reads busy is ignored: the entry it names is untouched, the window is not reloaded and the stored command word is unchanged.
- R10: When the page register holds any value other than 0x52B5, addresses 0x10-0x12 are three ordinary read/write 16-bit registers, and accesses to them neither start a debug access nor change the window or command.
- R11: On page 0x52B5, a write to 0x10 with bit 15 clear is stored as the command word but starts no access and moves no data.
- R12: Addresses other than 0x10-0x12 and 0x1F read as 0x0000, and writes to them are ignored. Read data is registered: it updates on the clock edge at which the read strobe is high and then holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 5 | Management register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data is valid after the edge at which it is high |
| reg_rdata | output | 16 | Registered read data |

## Verification
The main function is tried with several patterns. Two full write-then-read round trips to different entries show that the entries are independent and that the data halves are not swapped. An all-ones word shows that bits above the stored width are truncated. A command carrying the reserved bits 14 and 0 shows those bits are ignored. Pairs of addresses that differ only above the index width, or only within it, show how the index is built. Back-to-back commands, a command with the start bit clear, and standard-page traffic show apart three cases: a command that was really ignored, one that was silently executed, and one that was routed to the wrong register set.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

  localparam int REG_AW = 5;
  localparam int REG_DW = 16;
  localparam int CMD_W  = 16;
  localparam int ADDR_FULL_W = 12;
  localparam int STD_NUM = 3;

  localparam logic [REG_AW-1:0] PAGE_ADDR = 5'h1F;
  localparam logic [REG_AW-1:0] CMD_ADDR  = 5'h10;
  localparam logic [REG_AW-1:0] LO_ADDR   = 5'h11;
  localparam logic [REG_AW-1:0] HI_ADDR   = 5'h12;

  localparam logic [REG_DW-1:0] MAGIC_PAGE = 16'h52B5;

  // Command word layout, most significant bit first.
  typedef struct packed {
    logic       start;
    logic       rsvd_hi;
    logic       is_read;
    logic [1:0] chan;
    logic [3:0] node;
    logic [5:0] dword;
    logic       rsvd_lo;
  } dbg_cmd_t;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_EXEC = 2'd1,
    ACC_DONE = 2'd2
  } acc_state_t;

endpackage

// File: rtl/dbgw_rst_sync.sv
module dbgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dbgw_page_reg.sv
module dbgw_page_reg
  import dbgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] page_q,
  output logic              on_magic
);

  logic [REG_DW-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (wr_en) page_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign on_magic = (page_q == MAGIC_PAGE);

endmodule

// File: rtl/dbgw_cmd_ctrl.sv
module dbgw_cmd_ctrl
  import dbgw_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-2:0] cmd_q,
  output logic             busy,
  output logic             exec,
  output logic             exec_read,
  output logic [IDX_W-1:0] exec_idx
);

  acc_state_t       state_q, state_d;
  logic [CMD_W-2:0] cmd_d;
  dbg_cmd_t         cmd_view;
  dbg_cmd_t         new_cmd;
  logic [ADDR_FULL_W-1:0] full_addr;

  assign new_cmd = dbg_cmd_t'(wdata);

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    unique case (state_q)
      ACC_IDLE: begin
        if (cmd_wr) begin
          cmd_d = wdata[CMD_W-2:0];
          if (new_cmd.start) state_d = ACC_EXEC;
        end
      end
      ACC_EXEC: state_d = ACC_DONE;
      ACC_DONE: state_d = ACC_IDLE;
      default:  state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACC_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
    end
  end

  assign cmd_view  = dbg_cmd_t'({1'b0, cmd_q});
  assign full_addr = {cmd_view.chan, cmd_view.node, cmd_view.dword};
  assign exec_idx  = full_addr[IDX_W-1:0];
  assign exec_read = cmd_view.is_read;
  assign busy      = (state_q != ACC_IDLE);
  assign exec      = (state_q == ACC_EXEC);

endmodule

// File: rtl/dbgw_store.sv
module dbgw_store #(
  parameter int IDX_W   = 8,
  parameter int STORE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [STORE_W-1:0] wdata,
  output logic [STORE_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [STORE_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic ent_en;
    assign ent_en = we && (idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[e] <= '0;
      else if (ent_en) mem_q[e] <= wdata;
    end
  end

  assign rdata = mem_q[idx];

endmodule

// File: rtl/dbg_window_bridge.sv
module dbg_window_bridge #(
  parameter int IDX_W   = 8,
  parameter int STORE_W = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [dbgw_pkg::REG_AW-1:0]   reg_addr,
  input  logic [dbgw_pkg::REG_DW-1:0]   reg_wdata,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  output logic [dbgw_pkg::REG_DW-1:0]   reg_rdata
);
  import dbgw_pkg::*;

  localparam int HI_W = STORE_W - REG_DW;

  logic              rst_sync_n;
  logic [REG_DW-1:0] page_q;
  logic              on_magic;
  logic              hit_page, hit_cmd, hit_lo, hit_hi;
  logic              dbg_cmd_wr;
  logic [CMD_W-2:0]  cmd_q;
  logic              busy, exec, exec_read;
  logic [IDX_W-1:0]  exec_idx;
  logic [STORE_W-1:0] store_rd;
  logic              store_we;
  logic [2*REG_DW-1:0] win_word;
  logic [REG_DW-1:0] win_lo, win_hi, win_lo_d, win_hi_d;
  logic [REG_DW-1:0] std_q [STD_NUM];
  logic [REG_DW-1:0] rdata_d, rdata_q;

  dbgw_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign hit_page = (reg_addr == PAGE_ADDR);
  assign hit_cmd  = (reg_addr == CMD_ADDR);
  assign hit_lo   = (reg_addr == LO_ADDR);
  assign hit_hi   = (reg_addr == HI_ADDR);

  dbgw_page_reg i_page (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr && hit_page),
    .wdata(reg_wdata), .page_q(page_q), .on_magic(on_magic)
  );

  assign dbg_cmd_wr = reg_wr && on_magic && hit_cmd;

  dbgw_cmd_ctrl #(.IDX_W(IDX_W)) i_cmd (
    .clk(clk), .rst_n(rst_sync_n), .cmd_wr(dbg_cmd_wr), .wdata(reg_wdata),
    .cmd_q(cmd_q), .busy(busy), .exec(exec), .exec_read(exec_read),
    .exec_idx(exec_idx)
  );

  assign win_word = {win_hi, win_lo};
  assign store_we = exec && !exec_read;

  dbgw_store #(.IDX_W(IDX_W), .STORE_W(STORE_W)) i_store (
    .clk(clk), .rst_n(rst_sync_n), .we(store_we), .idx(exec_idx),
    .wdata(win_word[STORE_W-1:0]), .rdata(store_rd)
  );

  // Data window: an executing read load takes priority over port writes.
  always_comb begin
    win_lo_d = win_lo;
    win_hi_d = win_hi;
    if (exec && exec_read) begin
      win_lo_d = store_rd[REG_DW-1:0];
      win_hi_d = REG_DW'(store_rd[STORE_W-1:REG_DW]);
    end else begin
      if (reg_wr && on_magic && hit_lo) win_lo_d = reg_wdata;
      if (reg_wr && on_magic && hit_hi) win_hi_d = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      win_lo <= '0;
      win_hi <= '0;
    end else begin
      win_lo <= win_lo_d;
      win_hi <= win_hi_d;
    end
  end

  // Ordinary standard-page registers behind 0x10..0x12.
  for (genvar k = 0; k < STD_NUM; k++) begin : g_std
    logic std_en;
    assign std_en = reg_wr && !on_magic && (reg_addr == CMD_ADDR + REG_AW'(k));
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  std_q[k] <= '0;
      else if (std_en)  std_q[k] <= reg_wdata;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (hit_page)    rdata_d = page_q;
    else if (hit_cmd) rdata_d = on_magic ? {busy, cmd_q} : std_q[0];
    else if (hit_lo)  rdata_d = on_magic ? win_lo : std_q[1];
    else if (hit_hi)  rdata_d = on_magic ? win_hi : std_q[2];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (reg_rd)  rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/dbgw_checker.sv
module dbgw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_rdata,
  input logic [15:0] page_q,
  input logic        busy,
  input logic [14:0] cmd_q,
  input logic [15:0] win_lo,
  input logic [15:0] win_hi
);

  logic magic;
  assign magic = (page_q == 16'h52B5);

  AST_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'h1F) |=> (page_q == $past(reg_wdata))); // R2

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && magic && reg_addr == 5'h10 && reg_wdata[15] && !busy) |=> busy); // R8

  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy); // R8

  AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 5'h10) |=> $stable(cmd_q)); // R9

  AST_WINDOW_OFF_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!magic && !busy) |=> ($stable(win_lo) && $stable(win_hi))); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R12

endmodule

bind dbg_window_bridge dbgw_checker i_dbgw_checker (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .page_q(page_q),
  .busy(busy), .cmd_q(cmd_q), .win_lo(win_lo), .win_hi(win_hi)
);

// File: tb/test_dbg_window_bridge.sv
module test_dbg_window_bridge;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_rdata;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_window_bridge i_dbg_window_bridge (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] cmdw(input logic rd, input int ch, input int nd, input int da);
    return 16'h8000 | (16'(rd) << 13) | 16'((ch & 3) << 11) | 16'((nd & 15) << 7) | 16'((da & 63) << 1);
  endfunction

  function automatic logic [42:0] vec(input int req, input logic [1:0] op,
                                      input logic [4:0] a, input logic [15:0] d, input logic [15:0] e);
    return {4'(req), op, a, d, e};
  endfunction

  localparam int TBL_N = 31;
  localparam logic [42:0] TBL [TBL_N] = '{
    vec(2, OP_WR,  5'h1F, 16'h52B5, 16'h0),            // R2
    vec(2, OP_RD,  5'h1F, 16'h0,    16'h52B5),
    vec(3, OP_WR,  5'h11, 16'hBEEF, 16'h0),            // R3
    vec(3, OP_WR,  5'h12, 16'h00A5, 16'h0),
    vec(3, OP_RD,  5'h11, 16'h0,    16'hBEEF),
    vec(3, OP_RD,  5'h12, 16'h0,    16'h00A5),
    vec(4, OP_WR,  5'h10, cmdw(0, 1, 3, 'h17), 16'h0), // R4
    vec(4, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(4, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(4, OP_WR,  5'h11, 16'h0000, 16'h0),
    vec(4, OP_WR,  5'h12, 16'h0000, 16'h0),
    vec(5, OP_WR,  5'h10, cmdw(1, 1, 3, 'h17), 16'h0), // R5
    vec(5, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(5, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(5, OP_RD,  5'h11, 16'h0, 16'hBEEF),
    vec(5, OP_RD,  5'h12, 16'h0, 16'h00A5),
    vec(4, OP_WR,  5'h11, 16'h3456, 16'h0),
    vec(4, OP_WR,  5'h12, 16'h0012, 16'h0),
    vec(4, OP_WR,  5'h10, cmdw(0, 2, 0, 'h3F), 16'h0),
    vec(4, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(4, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(6, OP_WR,  5'h10, cmdw(1, 1, 3, 'h17), 16'h0), // R6
    vec(6, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(6, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(6, OP_RD,  5'h11, 16'h0, 16'hBEEF),
    vec(6, OP_RD,  5'h12, 16'h0, 16'h00A5),
    vec(5, OP_WR,  5'h10, cmdw(1, 2, 0, 'h3F), 16'h0),
    vec(5, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(5, OP_IDLE, 5'h0, 16'h0, 16'h0),
    vec(5, OP_RD,  5'h11, 16'h0, 16'h3456),
    vec(5, OP_RD,  5'h12, 16'h0, 16'h0012)
  };

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [15:0] e);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s addr=0x%02h actual=0x%04h expected=0x%04h", tag, a, reg_rdata, e);
    end
  endtask

  // Loads window, issues a commit, waits for it to finish.
  task automatic commit(input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] c);
    wr(5'h11, lo); wr(5'h12, hi); wr(5'h10, c); idle(2);
  endtask

  task automatic fetch(input logic [15:0] c);
    wr(5'h10, c); idle(2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    rd_chk("R1", 5'h1F, 16'h0000);
    rd_chk("R1", 5'h10, 16'h0000);
    rd_chk("R1", 5'h11, 16'h0000);

    for (int i = 0; i < TBL_N; i++) begin
      logic [42:0] e;
      e = TBL[i];
      case (e[38:37])
        OP_WR: wr(e[36:32], e[31:16]);
        OP_RD: rd_chk($sformatf("R%0d", e[42:39]), e[36:32], e[15:0]);
        default: idle(1);
      endcase
    end

    // R1: an untouched entry reads zero
    fetch(cmdw(1, 0, 0, 'h2A));
    rd_chk("R1", 5'h11, 16'h0000);
    rd_chk("R1", 5'h12, 16'h0000);

    // R8: busy for two cycles, then clear, command echoed
    wr(5'h11, 16'h0777); wr(5'h12, 16'h0000);
    wr(5'h10, cmdw(0, 0, 0, 1));
    rd_chk("R8", 5'h10, cmdw(0, 0, 0, 1));
    rd_chk("R8", 5'h10, cmdw(0, 0, 0, 1));
    rd_chk("R8", 5'h10, cmdw(0, 0, 0, 1) & 16'h7FFF);

    // R9: write command while busy is ignored
    wr(5'h11, 16'h1111);
    wr(5'h10, cmdw(0, 0, 0, 2));
    wr(5'h10, cmdw(0, 0, 0, 3));
    idle(2);
    rd_chk("R9", 5'h10, cmdw(0, 0, 0, 2) & 16'h7FFF);
    fetch(cmdw(1, 0, 0, 3));
    rd_chk("R9", 5'h11, 16'h0000);
    fetch(cmdw(1, 0, 0, 2));
    rd_chk("R9", 5'h11, 16'h1111);
    // R9: read command while busy does not reload window
    wr(5'h11, 16'hAAAA);
    wr(5'h10, cmdw(0, 0, 0, 4));
    wr(5'h10, cmdw(1, 0, 0, 2));
    idle(2);
    rd_chk("R9", 5'h11, 16'hAAAA);

    // R7: reserved bits 14 and 0 ignored
    commit(16'h5A5A, 16'h0033, cmdw(0, 1, 2, 9) | 16'h4001);
    wr(5'h11, 16'h0); wr(5'h12, 16'h0);
    fetch(cmdw(1, 1, 2, 9));
    rd_chk("R7", 5'h11, 16'h5A5A);
    rd_chk("R7", 5'h12, 16'h0033);

    // R4: bits above the stored width are dropped
    commit(16'hFFFF, 16'hFFFF, cmdw(0, 0, 1, 'h20));
    fetch(cmdw(1, 0, 1, 'h20));
    rd_chk("R4", 5'h11, 16'hFFFF);
    rd_chk("R4", 5'h12, 16'h00FF);

    // R6: alias above index width, distinct within it
    fetch(cmdw(1, 3, 6, 9));
    rd_chk("R6", 5'h11, 16'h5A5A);
    fetch(cmdw(1, 1, 1, 9));
    rd_chk("R6", 5'h11, 16'h0000);

    // R11: start bit clear moves nothing
    wr(5'h11, 16'h7777);
    wr(5'h10, 16'h2000 | 16'h0060);
    rd_chk("R11", 5'h10, 16'h2060);
    wr(5'h10, 16'h0060);
    idle(2);
    fetch(cmdw(1, 0, 0, 'h30));
    rd_chk("R11", 5'h11, 16'h0000);

    // R10: standard page registers
    wr(5'h1F, 16'h0000);
    wr(5'h11, 16'h1234);
    wr(5'h10, 16'hFFFF);
    wr(5'h12, 16'h00C3);
    idle(2);
    rd_chk("R10", 5'h11, 16'h1234);
    rd_chk("R10", 5'h10, 16'hFFFF);
    rd_chk("R10", 5'h12, 16'h00C3);
    wr(5'h1F, 16'h0001);
    rd_chk("R10", 5'h11, 16'h1234);
    wr(5'h1F, 16'h52B5);
    rd_chk("R10", 5'h11, 16'h0000);
    rd_chk("R10", 5'h10, cmdw(1, 0, 0, 'h30) & 16'h7FFF);

    // R12: unmapped address
    wr(5'h05, 16'hDEAD);
    rd_chk("R12", 5'h05, 16'h0000);
    rd_chk("R12", 5'h1E, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule